// File: doc/BRIEF.md
# Power Path Selector Sequencer

This block decides whether the system load is fed from the adapter or from the battery. It drives two switch-enable outputs, one for the adapter path and one for the battery path. Its inputs are digital flags from external comparators: the adapter is above the battery (the block is out of sleep), the supply is under the lockout level, the adapter is overvoltage, and the supply has fallen to within a small margin above the battery. All timing runs on a timebase strobe, and the two delays are parameters counted in strobes.

Every handover between sources first turns off the outgoing switch, then holds both switches off for a dead time, and only then turns on the incoming switch. The two directions are qualified differently. Moving to the adapter needs a long qualification window in which the adapter stays healthy. Moving back to the battery waits for the near-equal voltage flag or for an overvoltage. Undervoltage lockout bypasses every timer and returns the load to the battery at once. A two-bit status output shows which source is connected and reads zero during the dead time.

Top module: `pwr_path_seq`

## Requirements
- R1: After reset the battery switch is on, the adapter switch is off, and the status reads 2'b01.
- R2: While the adapter is not above the battery (sleep), or while overvoltage or undervoltage is flagged, the battery stays connected and the adapter switch stays off.
- R3: The handover to the adapter starts only after QUAL_TICKS strobes in which the adapter is healthy without a break. If sleep, overvoltage or undervoltage reasserts before then, the count starts again from zero.
- R4: Each handover holds both switches off for DEAD_TICKS strobes. The incoming switch turns on at the strobe that ends this window.
- R5: While the adapter is connected, losing the above-battery flag on its own keeps the adapter connected. The return to the battery begins in the cycle after the near-equal flag is seen.
- R6: An overvoltage flag while the adapter is connected starts a return to the battery that includes the dead time.
- R7: Undervoltage lockout in any state connects the battery and disconnects the adapter in the next cycle, with no dead time and no qualification.
- R8: The two switch-enable outputs are never high in the same cycle.
- R9: The status encoding is 2'b01 when the battery is connected, 2'b10 when the adapter is connected, and 2'b00 during a dead time.
- R10: Timers advance only on cycles where the strobe is high. With the strobe held low, no transition that depends on a timer takes place.
- R11: If the adapter goes to sleep or overvoltage during the dead time toward the adapter, the battery is reconnected in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_tick | input | 1 | Timebase strobe that advances both timers |
| adp_awake | input | 1 | Adapter is above the battery (out of sleep) |
| vcc_uvlo | input | 1 | Supply is below the undervoltage lockout level |
| adp_ovp | input | 1 | Adapter is overvoltage |
| vcc_near_bat | input | 1 | Supply is within the small margin above the battery |
| adp_sw_on | output | 1 | Enable for the adapter switch |
| bat_sw_on | output | 1 | Enable for the battery switch |
| src_stat | output | 2 | Connected source: 01 battery, 10 adapter, 00 dead time |

## Verification
The bench targets a fault pulse one strobe long that arrives just before the qualification window ends. A design that does not restart its count would move to the adapter too early. It checks that loss of the above-battery flag while on the adapter leaves the adapter connected. A design that keyed the return on that flag would drop the load before the supply is near the battery. Undervoltage is applied both in the middle of a dead time and while on the adapter, to catch designs that insert a dead time or wait on a timer. A phase with the strobe held low exposes timers that count clock cycles instead of strobes.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        ST_BAT    = 2'd0,
        ST_TO_ADP = 2'd1,
        ST_ADP    = 2'd2,
        ST_TO_BAT = 2'd3
    } pps_state_e;

    localparam logic [1:0] STAT_DEAD = 2'b00;
    localparam logic [1:0] STAT_BAT  = 2'b01;
    localparam logic [1:0] STAT_ADP  = 2'b10;

    typedef struct packed {
        pps_state_e state;
        logic       adp_on;
        logic       bat_on;
        logic [1:0] stat;
    } pps_regs_t;

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = !clear && tick && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear || done) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adp_awake,
    input  logic       vcc_uvlo,
    input  logic       adp_ovp,
    input  logic       vcc_near_bat,
    input  logic       qual_done,
    input  logic       dead_done,
    output logic       qual_clr,
    output logic       dead_clr,
    output logic       adp_on,
    output logic       bat_on,
    output logic [1:0] stat
);
    pps_regs_t r_d, r_q;
    logic      supply_ok;

    always_comb begin
        supply_ok = adp_awake && !adp_ovp && !vcc_uvlo;
        qual_clr  = !((r_q.state == ST_BAT) && supply_ok);
        dead_clr  = !((r_q.state == ST_TO_ADP) || (r_q.state == ST_TO_BAT));

        r_d = r_q;
        unique case (r_q.state)
            ST_BAT: begin
                if (qual_done) r_d.state = ST_TO_ADP;
            end
            ST_TO_ADP: begin
                if (!supply_ok)     r_d.state = ST_BAT;
                else if (dead_done) r_d.state = ST_ADP;
            end
            ST_ADP: begin
                if (vcc_uvlo)                     r_d.state = ST_BAT;
                else if (adp_ovp || vcc_near_bat) r_d.state = ST_TO_BAT;
            end
            ST_TO_BAT: begin
                if (vcc_uvlo || dead_done) r_d.state = ST_BAT;
            end
            default: r_d.state = ST_BAT;
        endcase

        r_d.adp_on = (r_d.state == ST_ADP);
        r_d.bat_on = (r_d.state == ST_BAT);
        unique case (r_d.state)
            ST_BAT:  r_d.stat = STAT_BAT;
            ST_ADP:  r_d.stat = STAT_ADP;
            default: r_d.stat = STAT_DEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_BAT;
            r_q.adp_on <= 1'b0;
            r_q.bat_on <= 1'b1;
            r_q.stat   <= STAT_BAT;
        end else begin
            r_q <= r_d;
        end
    end

    assign adp_on = r_q.adp_on;
    assign bat_on = r_q.bat_on;
    assign stat   = r_q.stat;
endmodule

// File: rtl/pwr_path_seq.sv
module pwr_path_seq #(
    parameter int QUAL_TICKS = 30000,
    parameter int DEAD_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       time_tick,
    input  logic       adp_awake,
    input  logic       vcc_uvlo,
    input  logic       adp_ovp,
    input  logic       vcc_near_bat,
    output logic       adp_sw_on,
    output logic       bat_sw_on,
    output logic [1:0] src_stat
);
    logic qual_clr, dead_clr, qual_done, dead_done;

    pps_tick_timer #(.LIMIT(QUAL_TICKS)) u_qual_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (qual_clr),
        .tick  (time_tick),
        .done  (qual_done)
    );

    pps_tick_timer #(.LIMIT(DEAD_TICKS)) u_dead_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dead_clr),
        .tick  (time_tick),
        .done  (dead_done)
    );

    pps_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .adp_awake    (adp_awake),
        .vcc_uvlo     (vcc_uvlo),
        .adp_ovp      (adp_ovp),
        .vcc_near_bat (vcc_near_bat),
        .qual_done    (qual_done),
        .dead_done    (dead_done),
        .qual_clr     (qual_clr),
        .dead_clr     (dead_clr),
        .adp_on       (adp_sw_on),
        .bat_on       (bat_sw_on),
        .stat         (src_stat)
    );
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       adp_awake,
    input logic       vcc_uvlo,
    input logic       adp_ovp,
    input logic       vcc_near_bat,
    input logic       adp_sw_on,
    input logic       bat_sw_on,
    input logic [1:0] src_stat
);
    AST_NEVER_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !(adp_sw_on && bat_sw_on)); // R8

    AST_UVLO_TO_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_uvlo |=> (bat_sw_on && !adp_sw_on)); // R7

    AST_ADP_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adp_sw_on) |-> !$past(bat_sw_on)); // R4

    AST_SLEEP_HOLDS_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sw_on && !adp_awake) |=> bat_sw_on); // R2

    AST_ADP_HOLD_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_sw_on && !vcc_near_bat && !adp_ovp && !vcc_uvlo) |=> adp_sw_on); // R5

    AST_STATUS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adp_sw_on && !bat_sw_on) |-> (src_stat == 2'b00)); // R9
endmodule

bind pwr_path_seq pps_checker u_pps_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .adp_awake    (adp_awake),
    .vcc_uvlo     (vcc_uvlo),
    .adp_ovp      (adp_ovp),
    .vcc_near_bat (vcc_near_bat),
    .adp_sw_on    (adp_sw_on),
    .bat_sw_on    (bat_sw_on),
    .src_stat     (src_stat)
);

// File: tb/pwr_path_seq_bench.sv
module pwr_path_seq_bench;
    localparam int Q = 20;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic time_tick = 1'b1;
    logic adp_awake = 1'b0;
    logic vcc_uvlo = 1'b0;
    logic adp_ovp = 1'b0;
    logic vcc_near_bat = 1'b0;
    logic adp_sw_on, bat_sw_on;
    logic [1:0] src_stat;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pwr_path_seq #(.QUAL_TICKS(Q), .DEAD_TICKS(D)) u_pwr_path_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .time_tick    (time_tick),
        .adp_awake    (adp_awake),
        .vcc_uvlo     (vcc_uvlo),
        .adp_ovp      (adp_ovp),
        .vcc_near_bat (vcc_near_bat),
        .adp_sw_on    (adp_sw_on),
        .bat_sw_on    (bat_sw_on),
        .src_stat     (src_stat)
    );

    // Reference model: 0 battery, 1 dead toward adapter, 2 adapter, 3 dead toward battery
    int ms, mq, md;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mq = 0; md = 0;
        end else begin
            case (ms)
                0: if (adp_awake && !adp_ovp && !vcc_uvlo) begin
                       if (time_tick) begin
                           if (mq == Q-1) begin ms = 1; mq = 0; end
                           else mq++;
                       end
                   end else mq = 0;
                1: if (!(adp_awake && !adp_ovp && !vcc_uvlo)) begin ms = 0; md = 0; end
                   else if (time_tick) begin
                       if (md == D-1) begin ms = 2; md = 0; end
                       else md++;
                   end
                2: if (vcc_uvlo) ms = 0;
                   else if (adp_ovp || vcc_near_bat) begin ms = 3; md = 0; end
                default: if (vcc_uvlo) begin ms = 0; md = 0; end
                   else if (time_tick) begin
                       if (md == D-1) begin ms = 0; md = 0; end
                       else md++;
                   end
            endcase
        end
    end

    function automatic logic [3:0] exp_of(int s);
        case (s)
            0:       return 4'b0101;
            2:       return 4'b1010;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [3:0] pack_out();
        return {adp_sw_on, bat_sw_on, src_stat};
    endfunction

    task automatic chk(string req, logic [3:0] exp);
        checks++;
        if (pack_out() !== exp) begin
            fails++;
            $display("FAIL %s: {adp,bat,stat} actual %b expected %b", req, pack_out(), exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [3:0] O_BAT  = 4'b0101;
    localparam logic [3:0] O_ADP  = 4'b1010;
    localparam logic [3:0] O_DEAD = 4'b0000;

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        chk("R1 reset state", O_BAT);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset release", O_BAT);

        // R2: sleep keeps battery
        step(50);
        chk("R2 sleep holds battery", O_BAT);
        adp_awake = 1'b1; adp_ovp = 1'b1;
        step(Q + 5);
        chk("R2 overvoltage holds battery", O_BAT);
        adp_ovp = 1'b0;

        // R3/R4/R9: qualification then dead time
        step(Q - 1);
        chk("R3 before qualification end", O_BAT);
        step(1);
        chk("R4 R9 dead time starts", O_DEAD);
        step(D - 1);
        chk("R4 dead time last", O_DEAD);
        step(1);
        chk("R4 R9 adapter connected", O_ADP);

        // R5: sleep alone keeps adapter, near flag returns
        adp_awake = 1'b0;
        step(10);
        chk("R5 awake low keeps adapter", O_ADP);
        vcc_near_bat = 1'b1;
        step(1);
        chk("R5 near flag starts dead", O_DEAD);
        step(D - 1);
        chk("R5 dead before battery", O_DEAD);
        step(1);
        chk("R5 battery reconnected", O_BAT);
        vcc_near_bat = 1'b0;

        // R3 restart on glitch
        adp_awake = 1'b1;
        step(Q - 2);
        adp_ovp = 1'b1;
        step(1);
        adp_ovp = 1'b0;
        step(Q - 1);
        chk("R3 count restarted", O_BAT);
        step(1);
        chk("R3 handover after restart", O_DEAD);
        step(D);
        chk("R4 adapter after dead", O_ADP);

        // R6: overvoltage on adapter
        adp_ovp = 1'b1;
        step(1);
        chk("R6 overvoltage dead", O_DEAD);
        step(D);
        chk("R6 overvoltage to battery", O_BAT);
        adp_ovp = 1'b0;
        step(Q + D);
        chk("R3 requalified", O_ADP);

        // R7: undervoltage on adapter
        vcc_uvlo = 1'b1;
        step(1);
        chk("R7 uvlo from adapter", O_BAT);
        vcc_uvlo = 1'b0;
        step(Q + 1);
        chk("R4 in dead toward adapter", O_DEAD);
        vcc_uvlo = 1'b1;
        step(1);
        chk("R7 uvlo from dead", O_BAT);
        vcc_uvlo = 1'b0;

        // R11: sleep during dead toward adapter
        step(Q + 1);
        chk("R11 setup dead", O_DEAD);
        adp_awake = 1'b0;
        step(1);
        chk("R11 sleep in dead returns battery", O_BAT);

        // R10: strobe held low
        time_tick = 1'b0;
        adp_awake = 1'b1;
        step(200);
        chk("R10 no strobe no handover", O_BAT);
        time_tick = 1'b1;
        step(Q - 1);
        chk("R10 strobes counted", O_BAT);
        step(1);
        chk("R10 handover on strobe", O_DEAD);
        time_tick = 1'b0;
        step(50);
        chk("R10 dead holds without strobe", O_DEAD);
        time_tick = 1'b1;
        step(D);
        chk("R10 adapter after strobes", O_ADP);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            chk("R8 R3 R4 R5 R6 R7 R11 model", exp_of(ms));
            if (adp_sw_on && bat_sw_on) chk("R8 exclusive", 4'b0000);
            time_tick = ($urandom_range(3, 0) != 0);
            if ($urandom_range(29, 0) == 0) adp_awake = ~adp_awake;
            if ($urandom_range(59, 0) == 0) adp_ovp = ~adp_ovp;
            if ($urandom_range(99, 0) == 0) vcc_uvlo = ~vcc_uvlo;
            if ($urandom_range(39, 0) == 0) vcc_near_bat = ~vcc_near_bat;
            step(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule